// File: doc/BRIEF.md
# Edge-triggered interrupt request register

This block turns transitions on four asynchronous pins into latched interrupt requests that software can read over a simple byte-wide register bus. Two pins each own a dedicated request bit. The other two are counter inputs, and they share a third request bit. A select control decides which of those two counter pins can set the shared bit. Every pin has its own polarity control, which arms it for either a falling or a rising transition.

All four pins are also general input port bits. Their synchronized levels can therefore be read back through a separate level register. A request bit stays set until software writes 0 to that bit position. If a new transition and a clear write arrive in the same cycle, the new transition wins. The read path is combinational on the address, and writes take effect at the next rising clock edge.

The block has three registers. The request register is at `REQ_ADDR` (default 0xFD). The control register is at `CTRL_ADDR` (default 0xFE). The level register is at `LVL_ADDR` (default 0xE3).

Top module: `edgeIrqReg`

## Requirements
- R1: After reset the request register reads 0x00. The control register also reads 0x00, which means every pin is armed for a falling transition and counter pin 2 is selected.
- R2: When pin 0 makes a transition in its armed direction, request bit 0 reads 1 after the third rising clock edge that follows the pin change.
- R3: When pin 1 makes a transition in its armed direction, request bit 1 reads 1, with the same latency as in R2.
- R4: Request bit 2 is set by an armed transition on pin 2 when control bit 4 is 0, and on pin 3 when control bit 4 is 1. A transition on the pin that is not selected never sets request bit 2.
- R5: Control bit n (n = 0 to 3) sets the armed direction of pin n: 0 arms a falling transition and 1 arms a rising transition. A transition in the other direction sets nothing.
- R6: Each armed transition sets its request bit exactly once. A pin that holds a steady level does not set the bit again after it has been cleared.
- R7: A write to the request register clears every bit 0 to 2 whose written value is 0. A bit whose written value is 1 keeps its present state. Bits 7 to 3 always read 0.
- R8: If a write clears a request bit in the same cycle that an armed transition sets it, the bit reads 1 afterwards.
- R9: Changing control bit 4 never sets request bit 2 by itself, even when the two counter pins sit at different levels.
- R10: The level register shows the synchronized level of pin n in bit n (n = 0 to 3), with bits 7 to 4 reading 0. A pin change appears there after the second rising clock edge.
- R11: A write to the control register stores bits 4 to 0, and they read back unchanged. Bits 7 to 5 read 0. The control register keeps its value when no write addresses it.
- R12: Reads from any other address return 0x00, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 4 | Asynchronous pins: 0 and 1 are interrupt pins, 2 and 3 are counter pins |
| busAddr | input | ADDR_W | Register address for both reads and writes |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data for `busAddr`, combinational |

## Verification
The assertions assume that reset leaves the synchronizer chain and the previous-level register at 0. They therefore treat a pin that is high after reset as a genuine rising transition. They also assume that a write is a single-cycle strobe whose data is valid in the same cycle. The stimulus holds every pin low during reset and changes pins and bus signals only on the falling clock edge. That keeps each pin change at least one full cycle away from the edge that samples it, so the three-edge latency is deterministic. Directed steps place a clear write in exactly the cycle when a pending transition lands, and they toggle the select while the two counter pins sit at different levels. After that, a long pseudo-random phase mixes pin toggles and writes at every address.

// File: rtl/edgeIrqPkg.sv
package edgeIrqPkg;
  localparam int NUM_PINS = 4;
  localparam int REQ_BITS = 3;
  localparam int CTRL_BITS = NUM_PINS + 1;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_REQ  = 2'd1,
    RD_CTRL = 2'd2,
    RD_LVL  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   reqWr;
    logic   ctrlWr;
    rdSel_e rdSel;
  } irqStrobes_t;
endpackage

// File: rtl/edgeIrqCtrl.sv
module edgeIrqCtrl
  import edgeIrqPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REQ_ADDR = 8'hFD,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hFE,
  parameter logic [ADDR_W-1:0] LVL_ADDR = 8'hE3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output irqStrobes_t       strobes
);
  logic hitReq, hitCtrl, hitLvl;

  assign hitReq  = (busAddr == REQ_ADDR);
  assign hitCtrl = (busAddr == CTRL_ADDR);
  assign hitLvl  = (busAddr == LVL_ADDR);

  always_comb begin
    strobes.reqWr  = busWrEn && hitReq;
    strobes.ctrlWr = busWrEn && hitCtrl;
    if (hitReq)       strobes.rdSel = RD_REQ;
    else if (hitCtrl) strobes.rdSel = RD_CTRL;
    else if (hitLvl)  strobes.rdSel = RD_LVL;
    else              strobes.rdSel = RD_NONE;
  end
endmodule

// File: rtl/edgeIrqDatapath.sv
module edgeIrqDatapath
  import edgeIrqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [DATA_W-1:0]   busWrData,
  input  irqStrobes_t         strobes,
  output logic [DATA_W-1:0]   busRdData,
  output logic [REQ_BITS-1:0] reqVec,
  output logic [NUM_PINS-1:0] polVec,
  output logic                selBit,
  output logic [NUM_PINS-1:0] lvlVec
);
  localparam int REQ_PAD = DATA_W - REQ_BITS;
  localparam int CTRL_PAD = DATA_W - CTRL_BITS;
  localparam int LVL_PAD = DATA_W - NUM_PINS;

  logic [NUM_PINS-1:0] prevLvl;
  logic [NUM_PINS-1:0] edgeHit;
  logic [REQ_BITS-1:0] setVec;
  logic [REQ_BITS-1:0] keepVec;

  // One synchronizer chain per pin, followed by an edge detector
  // that compares the current level with the previous one.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], pinIn[p]};
    end
    assign lvlVec[p]  = chain[SYNC_STAGES-1];
    assign edgeHit[p] = (lvlVec[p] ^ prevLvl[p]) & ~(lvlVec[p] ^ polVec[p]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= lvlVec;
  end

  // Both counter pins keep their edge tracking all the time.
  // The select only decides which detector reaches request bit 2.
  assign setVec = {selBit ? edgeHit[3] : edgeHit[2], edgeHit[1], edgeHit[0]};
  assign keepVec = strobes.reqWr ? (reqVec & busWrData[REQ_BITS-1:0]) : reqVec;

  always_ff @(posedge clk) begin
    if (!rstN) reqVec <= '0;
    else       reqVec <= keepVec | setVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      polVec <= '0;
      selBit <= 1'b0;
    end else if (strobes.ctrlWr) begin
      polVec <= busWrData[NUM_PINS-1:0];
      selBit <= busWrData[NUM_PINS];
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_REQ:  busRdData = {{REQ_PAD{1'b0}}, reqVec};
      RD_CTRL: busRdData = {{CTRL_PAD{1'b0}}, selBit, polVec};
      RD_LVL:  busRdData = {{LVL_PAD{1'b0}}, lvlVec};
      default: busRdData = '0;
    endcase
  end
endmodule

// File: rtl/edgeIrqReg.sv
module edgeIrqReg
  import edgeIrqPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] REQ_ADDR = 8'hFD,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hFE,
  parameter logic [ADDR_W-1:0] LVL_ADDR = 8'hE3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        pinIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData
);
  irqStrobes_t         strobes;
  logic [REQ_BITS-1:0] reqVec;
  logic [NUM_PINS-1:0] polVec;
  logic                selBit;
  logic [NUM_PINS-1:0] lvlVec;

  edgeIrqCtrl #(
    .ADDR_W(ADDR_W), .REQ_ADDR(REQ_ADDR), .CTRL_ADDR(CTRL_ADDR), .LVL_ADDR(LVL_ADDR)
  ) i_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .strobes(strobes)
  );

  edgeIrqDatapath #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busWrData(busWrData),
    .strobes(strobes), .busRdData(busRdData), .reqVec(reqVec),
    .polVec(polVec), .selBit(selBit), .lvlVec(lvlVec)
  );
endmodule

// File: rtl/edgeIrqChecker.sv
module edgeIrqChecker
  import edgeIrqPkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input irqStrobes_t         strobes,
  input logic [DATA_W-1:0]   busWrData,
  input logic [REQ_BITS-1:0] reqVec,
  input logic [NUM_PINS-1:0] polVec,
  input logic                selBit,
  input logic [NUM_PINS-1:0] lvlVec
);
  assert_int0_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lvlVec[0] != $past(lvlVec[0])) && (lvlVec[0] == polVec[0]) |=> reqVec[0]);

  assert_int1_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lvlVec[1] != $past(lvlVec[1])) && (lvlVec[1] == polVec[1]) |=> reqVec[1]);

  assert_cntr_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (selBit ? ((lvlVec[3] != $past(lvlVec[3])) && (lvlVec[3] == polVec[3]))
            : ((lvlVec[2] != $past(lvlVec[2])) && (lvlVec[2] == polVec[2])))
    |=> reqVec[2]);

  assert_int0_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqVec[0]) |->
      ($past(lvlVec[0]) != $past(lvlVec[0], 2)) && ($past(lvlVec[0]) == $past(polVec[0])));

  assert_int1_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqVec[1]) |->
      ($past(lvlVec[1]) != $past(lvlVec[1], 2)) && ($past(lvlVec[1]) == $past(polVec[1])));

  assert_cntr_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqVec[2]) |->
      ($past(selBit)
        ? (($past(lvlVec[3]) != $past(lvlVec[3], 2)) && ($past(lvlVec[3]) == $past(polVec[3])))
        : (($past(lvlVec[2]) != $past(lvlVec[2], 2)) && ($past(lvlVec[2]) == $past(polVec[2])))));

  for (genvar b = 0; b < REQ_BITS; b++) begin : g_clr
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(reqVec[b]) |-> $past(strobes.reqWr && !busWrData[b]));
  end

  assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.ctrlWr |=> $stable(polVec) && $stable(selBit));
endmodule

bind edgeIrqReg edgeIrqChecker #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .busWrData(busWrData),
  .reqVec(reqVec), .polVec(polVec), .selBit(selBit), .lvlVec(lvlVec)
);

// File: tb/test_edgeIrqReg.sv
module test_edgeIrqReg;
  localparam logic [7:0] REQ_A = 8'hFD;
  localparam logic [7:0] CTRL_A = 8'hFE;
  localparam logic [7:0] LVL_A = 8'hE3;
  localparam logic [7:0] OTHER_A = 8'h10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] pinIn = '0;
  logic [7:0] busAddr = '0;
  logic busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  edgeIrqReg i_edgeIrqReg (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData)
  );

  // Reference model. hist holds the pin samples of the last three clocks.
  logic [3:0] hist[$];
  logic [2:0] mReq;
  logic [3:0] mPol;
  logic mSel;

  always @(posedge clk) begin
    logic [3:0] cur, prv, hit;
    logic [2:0] setB;
    if (!rstN) begin
      hist = '{4'h0, 4'h0, 4'h0};
      mReq = '0; mPol = '0; mSel = 1'b0;
    end else begin
      hist.push_back(pinIn);
      cur = hist[hist.size() - 3];
      prv = hist[hist.size() - 4];
      for (int i = 0; i < 4; i++) hit[i] = (cur[i] != prv[i]) && (cur[i] == mPol[i]);
      setB = {mSel ? hit[3] : hit[2], hit[1], hit[0]};
      if (busWrEn && busAddr == REQ_A) mReq = mReq & busWrData[2:0];
      mReq = mReq | setB;
      if (busWrEn && busAddr == CTRL_A) begin
        mPol = busWrData[3:0];
        mSel = busWrData[4];
      end
      while (hist.size() > 3) void'(hist.pop_front());
    end
  end

  function automatic logic [7:0] modelRead(input logic [7:0] a);
    if (a == REQ_A) return {5'b0, mReq};
    if (a == CTRL_A) return {3'b0, mSel, mPol};
    if (a == LVL_A) return {4'b0, hist[1]};
    return 8'h00;
  endfunction

  task automatic step(input logic [3:0] pins, input logic [7:0] a, input logic we,
                      input logic [7:0] wd, input string tag);
    logic [7:0] expv;
    @(negedge clk);
    pinIn = pins; busAddr = a; busWrEn = we; busWrData = wd;
    #1;
    expv = modelRead(a);
    compared++;
    if (busRdData !== expv) begin
      mismatched++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, busRdData, expv);
    end
  endtask

  task automatic idle(input int n, input logic [7:0] a, input string tag);
    for (int i = 0; i < n; i++) step(pinIn, a, 1'b0, 8'h00, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    step(4'h0, REQ_A, 1'b0, 8'h00, "R1");
    step(4'h0, CTRL_A, 1'b0, 8'h00, "R1");
    // R5: rise on pin 0 while it is armed for a fall sets nothing
    step(4'h1, REQ_A, 1'b0, 8'h00, "R5");
    idle(4, REQ_A, "R5");
    step(4'h1, LVL_A, 1'b0, 8'h00, "R10");
    // R2: falling edge on pin 0
    step(4'h0, REQ_A, 1'b0, 8'h00, "R2");
    idle(4, REQ_A, "R2");
    // R3 and R11: arm pin 1 for a rise
    step(4'h0, CTRL_A, 1'b1, 8'h02, "R11");
    idle(1, CTRL_A, "R11");
    step(4'h2, REQ_A, 1'b0, 8'h00, "R3");
    idle(4, REQ_A, "R3");
    // R7: clear bit 0 only; R6: held level does not set it again
    step(4'h2, REQ_A, 1'b1, 8'hFE, "R7");
    idle(4, REQ_A, "R6");
    step(4'h2, REQ_A, 1'b1, 8'h00, "R7");
    idle(3, REQ_A, "R6");
    // R4: pin 2 with select 0 (armed for a rise)
    step(4'h2, CTRL_A, 1'b1, 8'h0C, "R11");
    step(4'h6, REQ_A, 1'b0, 8'h00, "R4");
    idle(4, REQ_A, "R4");
    step(4'h6, REQ_A, 1'b1, 8'h00, "R7");
    // R4: pin 3 is not selected and must not set bit 2
    step(4'hE, REQ_A, 1'b0, 8'h00, "R4");
    idle(4, REQ_A, "R4");
    // R9: counter pins at different levels, then flip the select
    step(4'h6, REQ_A, 1'b0, 8'h00, "R9");
    idle(4, REQ_A, "R9");
    step(4'h6, CTRL_A, 1'b1, 8'h1C, "R9");
    idle(4, REQ_A, "R9");
    step(4'hE, REQ_A, 1'b0, 8'h00, "R4");
    idle(4, REQ_A, "R4");
    // R8: a clear write lands in the cycle of a new set
    step(4'hE, REQ_A, 1'b1, 8'h00, "R8");
    step(4'h6, CTRL_A, 1'b1, 8'h14, "R8");
    step(4'h6, REQ_A, 1'b0, 8'h00, "R8");
    step(4'h6, REQ_A, 1'b1, 8'h00, "R8");
    idle(3, REQ_A, "R8");
    // R12: other addresses read zero; writes there change nothing
    step(4'h6, OTHER_A, 1'b1, 8'hFF, "R12");
    step(4'h6, CTRL_A, 1'b0, 8'h00, "R12");
    step(4'h6, REQ_A, 1'b0, 8'h00, "R12");
    // pseudo-random mix
    for (int n = 0; n < 4000; n++) begin
      logic [3:0] pins;
      logic [7:0] a;
      string tag;
      pins = pinIn;
      for (int b = 0; b < 4; b++) if ($urandom_range(7) == 0) pins[b] = ~pins[b];
      case ($urandom_range(3))
        0: begin a = REQ_A; tag = "R7"; end
        1: begin a = CTRL_A; tag = "R11"; end
        2: begin a = LVL_A; tag = "R10"; end
        default: begin a = OTHER_A; tag = "R12"; end
      endcase
      step(pins, a, $urandom_range(5) == 0, 8'($urandom), tag);
    end
    summary();
  end
endmodule